// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide register front end for a three-channel interval timer. A host reaches it through a 2-bit address. Addresses 0, 1 and 2 carry count bytes for the matching channel, and address 3 accepts control words. The block holds, for each channel, the byte-access style, the counting mode and the decimal flag. It splits 16-bit counts into byte transfers and joins them back together. It also handles count snapshots, the multi-channel readback command and the status byte.

The counting logic sits in the channels, outside this block. When a count is complete, the block pulses one load strobe per channel and presents the 16-bit value on a shared bus. It samples each channel's running count and output level when it needs them for a snapshot, a status byte or a live read.

Top module: `tmr_host_if`

## Requirements
- R1: After reset every channel uses two-byte access (low byte first), counting mode 3 and a cleared decimal flag. No snapshot or status is pending, and both byte toggles point at the low byte.
- R2: A control word at address 3 is decoded as follows: bits 7:6 select the channel, bits 5:4 the access style (1 low only, 2 high only, 3 low then high), bits 3:1 the mode and bit 0 the decimal flag. When the access field is nonzero, the channel's mode outputs update and its read and write toggles return to the low byte.
- R3: A control word whose access field is 0 snapshots that channel's running count. It leaves the channel's mode, decimal flag and access style unchanged.
- R4: Count writes load as follows. Low-only loads {8'h00, byte}. High-only loads {byte, 8'h00}. Two-byte access holds the first byte and loads {second, first} on the second write. The single load strobe of the addressed channel pulses in the cycle after the loading write.
- R5: Live reads return the low byte for low-only access and the high byte for high-only access. Two-byte access alternates low, high, low, and so on.
- R6: A count snapshot keeps the value from the moment it was taken and is not replaced by later latch requests until it has been read. Its bytes are read in the channel's access style, and a two-byte snapshot is released after its high byte.
- R7: A control word with bits 7:6 = 3 is a readback command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 at 0 snapshots the count, and bit 4 at 0 latches the status.
- R8: The status byte holds the output level in bit 7, 0 in bit 6, the access style in bits 5:4, the mode in bits 3:1 and the decimal flag in bit 0. A pending status is not replaced until it has been read.
- R9: A read returns a pending status first, then a pending count snapshot, and only then the live count.
- R10: Read data appears on rdata with rd_valid in the cycle after rd_en. A read of address 3 returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte |
| rd_valid | output | 1 | rdata holds the result of the previous read |
| live_cnt | input | 48 | Running counts, channel n in bits 16n+15:16n |
| out_lvl | input | 3 | Channel output levels |
| load_stb | output | 3 | Per-channel count load pulse |
| load_val | output | 16 | Count being loaded |
| ch_mode | output | 9 | Counting mode, channel n in bits 3n+2:3n |
| ch_bcd | output | 3 | Per-channel decimal flag |

## Verification
The assertions assume that rd_en and wr_en are never high in the same cycle. They also assume that each strobe lasts exactly one cycle. The bench's driver tasks raise a single strobe for one clock and drop it before the next access begins. The assertions further assume that live_cnt and out_lvl are stable around the edge that takes a snapshot. The bench changes these inputs only between accesses, so the expected snapshot is always the value present at the latching write.

// File: rtl/tmr_host_if.sv
module tmr_host_if (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        rd_valid,
  input  logic [47:0] live_cnt,
  input  logic [2:0]  out_lvl,
  output logic [2:0]  load_stb,
  output logic [15:0] load_val,
  output logic [8:0]  ch_mode,
  output logic [2:0]  ch_bcd
);

  logic [1:0]  acc  [3];
  logic [2:0]  mode [3];
  logic        dec  [3];
  logic        wph  [3];
  logic        rph  [3];
  logic [7:0]  wlat [3];
  logic [1:0]  clat [3];
  logic [15:0] lcnt [3];
  logic        slat [3];
  logic [7:0]  stat [3];
  logic [15:0] live [3];

  for (genvar g = 0; g < 3; g++) begin : g_ch
    assign live[g]          = live_cnt[16*g +: 16];
    assign ch_mode[3*g +: 3] = mode[g];
    assign ch_bcd[g]        = dec[g];

    a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (clat[g] != 2'd0 && !(rd_en && addr == 2'(g))) |=> (clat[g] != 2'd0 && $stable(lcnt[g])));

    a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (slat[g] && !(rd_en && addr == 2'(g))) |=> (slat[g] && $stable(stat[g])));

    a_r2_toggle_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && wdata[7:6] == 2'(g) && wdata[5:4] != 2'd0)
      |=> (!wph[g] && !rph[g] && ch_mode[3*g +: 3] == $past(wdata[3:1])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_stb <= '0;
      load_val <= '0;
      rdata    <= '0;
      rd_valid <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        acc[i]  <= 2'd3;
        mode[i] <= 3'd3;
        dec[i]  <= 1'b0;
        wph[i]  <= 1'b0;
        rph[i]  <= 1'b0;
        wlat[i] <= '0;
        clat[i] <= 2'd0;
        lcnt[i] <= '0;
        slat[i] <= 1'b0;
        stat[i] <= '0;
      end
    end else begin
      load_stb <= '0;
      rd_valid <= rd_en;
      if (wr_en) begin
        for (int i = 0; i < 3; i++) begin
          if (addr == 2'd3) begin
            if (wdata[7:6] == 2'd3) begin
              if (wdata[i+1]) begin
                if (!wdata[5] && clat[i] == 2'd0) begin
                  lcnt[i] <= live[i];
                  clat[i] <= acc[i];
                end
                if (!wdata[4] && !slat[i]) begin
                  stat[i] <= {out_lvl[i], 1'b0, acc[i], mode[i], dec[i]};
                  slat[i] <= 1'b1;
                end
              end
            end else if (wdata[7:6] == 2'(i)) begin
              if (wdata[5:4] == 2'd0) begin
                if (clat[i] == 2'd0) begin
                  lcnt[i] <= live[i];
                  clat[i] <= acc[i];
                end
              end else begin
                acc[i]  <= wdata[5:4];
                mode[i] <= wdata[3:1];
                dec[i]  <= wdata[0];
                wph[i]  <= 1'b0;
                rph[i]  <= 1'b0;
              end
            end
          end else if (addr == 2'(i)) begin
            case (acc[i])
              2'd1: begin
                load_stb[i] <= 1'b1;
                load_val    <= {8'h00, wdata};
              end
              2'd2: begin
                load_stb[i] <= 1'b1;
                load_val    <= {wdata, 8'h00};
              end
              default: begin
                if (!wph[i]) begin
                  wlat[i] <= wdata;
                  wph[i]  <= 1'b1;
                end else begin
                  load_stb[i] <= 1'b1;
                  load_val    <= {wdata, wlat[i]};
                  wph[i]      <= 1'b0;
                end
              end
            endcase
          end
        end
      end
      if (rd_en) begin
        rdata <= 8'h00;
        for (int i = 0; i < 3; i++) begin
          if (addr == 2'(i)) begin
            if (slat[i]) begin
              rdata   <= stat[i];
              slat[i] <= 1'b0;
            end else if (clat[i] != 2'd0) begin
              case (clat[i])
                2'd1: begin rdata <= lcnt[i][7:0];  clat[i] <= 2'd0; end
                2'd2: begin rdata <= lcnt[i][15:8]; clat[i] <= 2'd0; end
                default: begin rdata <= lcnt[i][7:0]; clat[i] <= 2'd2; end
              endcase
            end else begin
              case (acc[i])
                2'd1: rdata <= live[i][7:0];
                2'd2: rdata <= live[i][15:8];
                default: begin
                  rdata  <= rph[i] ? live[i][15:8] : live[i][7:0];
                  rph[i] <= ~rph[i];
                end
              endcase
            end
          end
        end
      end
    end
  end

  a_r4_one_load: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(load_stb));

  a_r4_load_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != 2'd3) |=> ($countones(load_stb) <= 1));

  a_r4_load_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || addr == 2'd3) |=> (load_stb == 3'b000));

  a_r10_ctrl_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |=> (rd_valid && rdata == 8'h00));

endmodule

// File: tb/tmr_host_if_bench.sv
`timescale 1ns/1ps
module tmr_host_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rd_valid;
  logic [15:0] lv [3];
  logic [47:0] live_cnt;
  logic [2:0]  out_lvl = '0;
  logic [2:0]  load_stb;
  logic [15:0] load_val;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] v; string tag; } rexp_t;
  typedef struct { logic [2:0] s; logic [15:0] v; string tag; } lexp_t;
  rexp_t rq[$];
  lexp_t lq[$];

  assign live_cnt = {lv[2], lv[1], lv[0]};
  always #10 clk = ~clk;

  tmr_host_if u_tmr_host_if (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .live_cnt(live_cnt),
    .out_lvl(out_lvl), .load_stb(load_stb), .load_val(load_val),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    rexp_t x;
    x.v = e; x.tag = tag;
    rq.push_back(x);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic exp_load(input logic [2:0] s, input logic [15:0] v, input string tag);
    lexp_t x;
    x.s = s; x.v = v; x.tag = tag;
    lq.push_back(x);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (rq.size() == 0) chk(1'b0, "R10 unexpected read data", {24'h0, rdata}, 32'h0);
      else begin
        rexp_t x;
        x = rq.pop_front();
        chk(rdata == x.v, x.tag, {24'h0, rdata}, {24'h0, x.v});
      end
    end
    if (rst_n && |load_stb) begin
      if (lq.size() == 0) chk(1'b0, "R4 unexpected load", {13'h0, load_stb, load_val}, 32'h0);
      else begin
        lexp_t y;
        y = lq.pop_front();
        chk(load_stb == y.s && load_val == y.v, y.tag, {13'h0, load_stb, load_val}, {13'h0, y.s, y.v});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    lv[0] = 16'h1234; lv[1] = 16'h0; lv[2] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ch_mode == 9'b011011011, "R1 reset modes", {23'h0, ch_mode}, 32'h0db);
    chk(ch_bcd == 3'b000, "R1 reset decimal flags", {29'h0, ch_bcd}, 32'h0);
    rd(2'd0, 8'h34, "R1 R5 reset word read low");
    rd(2'd0, 8'h12, "R5 word read high");
    rd(2'd0, 8'h34, "R5 word read alternates");

    // R2 R4 word write on channel 1
    wr(2'd3, 8'h70);
    chk(ch_mode[5:3] == 3'd0, "R2 ch1 mode 0", {29'h0, ch_mode[5:3]}, 32'h0);
    wr(2'd1, 8'h11);
    exp_load(3'b010, 16'h2211, "R4 word load ch1");
    wr(2'd1, 8'h22);

    // low-only on channel 2, mode 2, decimal flag set
    wr(2'd3, 8'h95);
    chk(ch_mode[8:6] == 3'd2 && ch_bcd[2], "R2 ch2 mode and flag", {28'h0, ch_bcd[2], ch_mode[8:6]}, 32'ha);
    exp_load(3'b100, 16'h007A, "R4 low-only load ch2");
    wr(2'd2, 8'h7A);
    lv[2] = 16'hBEEF;
    rd(2'd2, 8'hEF, "R5 low-only read");
    rd(2'd2, 8'hEF, "R5 low-only read repeats");

    // high-only on channel 0, mode 3
    wr(2'd3, 8'h26);
    exp_load(3'b001, 16'h5C00, "R4 high-only load ch0");
    wr(2'd0, 8'h5C);
    rd(2'd0, 8'h12, "R5 high-only read");

    // R3 R6 latch via access 0
    lv[1] = 16'hA1B2;
    wr(2'd3, 8'h4E);
    chk(ch_mode[5:3] == 3'd0, "R3 latch leaves mode", {29'h0, ch_mode[5:3]}, 32'h0);
    lv[1] = 16'h0000;
    wr(2'd3, 8'h40);
    rd(2'd1, 8'hB2, "R6 snapshot low");
    rd(2'd1, 8'hA1, "R6 snapshot high, not relatched");
    lv[1] = 16'h5566;
    rd(2'd1, 8'h66, "R6 R3 live after release, word low");
    rd(2'd1, 8'h55, "R3 word access kept");

    // R2 toggle reset by control word
    wr(2'd1, 8'h33);
    wr(2'd3, 8'h70);
    exp_load(3'b010, 16'h5544, "R2 write toggle reset");
    wr(2'd1, 8'h44);
    wr(2'd1, 8'h55);

    // R7 R8 R9 readback of ch0 and ch2
    out_lvl = 3'b001;
    lv[0] = 16'h1357; lv[2] = 16'h2468;
    wr(2'd3, 8'hCA);
    chk(ch_mode == 9'b010000011, "R7 readback leaves modes", {23'h0, ch_mode}, 32'h083);
    out_lvl = 3'b000;
    lv[0] = 16'hFFEE; lv[2] = 16'h1111;
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'hA6, "R8 R9 status first ch0, not relatched");
    rd(2'd0, 8'h13, "R9 R6 snapshot high-only ch0");
    rd(2'd0, 8'hFF, "R9 then live ch0");
    rd(2'd2, 8'h15, "R8 status ch2");
    rd(2'd2, 8'h68, "R7 snapshot ch2 low-only");
    rd(2'd2, 8'h11, "R9 live ch2");
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'h26, "R8 fresh status with output low");

    // R7 count-only readback of ch1
    lv[1] = 16'h0F0E;
    wr(2'd3, 8'hD4);
    lv[1] = 16'hAAAA;
    rd(2'd1, 8'h0E, "R7 count-only readback low");
    rd(2'd1, 8'h0F, "R7 count-only readback high");

    // R10 control address read
    rd(2'd3, 8'h00, "R10 address 3 reads zero");

    repeat (4) @(negedge clk);
    chk(rq.size() == 0, "R10 all reads returned", rq.size(), 0);
    chk(lq.size() == 0, "R4 all loads seen", lq.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule